// File: doc/BRIEF.md
# Capture-Reload Down-Counter Timer

This block is a down-counting timer with a reload register, a capture register and two external event inputs, called A and B. Software sets it up through a small register bus. It writes the reload value and the control bits (a run bit and a two-bit mode select). It reads back the capture register, the live count and a four-bit status word. Input A only records that an event occurred. Input B takes part in timing: it can snapshot the counter, restart it, or both.

There are two modes. In hardware-restart mode, each B event while running snapshots the counter (when B has no pending flag or error) and then restarts it from the reload value. This measures the interval between successive B edges. In software-restart mode, setting the run bit starts the count from the reload value, and B events only take snapshots. Each input keeps a flag that marks a pending event, and an error bit that marks an overrun. Both bits are cleared by writing 1 to them.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the counter, the capture register, the control register and all four status bits read 0.
- R2: Bus map, with reads combinational on `rd_data`. Address 0 is the reload value (read/write). Address 1 is the capture value (read only). Address 2 is control: bit 0 run, bit 1 select-low, bit 2 select-high (read/write). Address 3 is status: bit 0 A flag, bit 1 A error, bit 2 B flag, bit 3 B error. Address 4 is the live count (read only).
- R3: Software-restart mode is select {high,low} = 00. A control write that takes run from 0 to 1 loads the counter from the reload register at that edge. The counter then falls by one per clock and stops at 0000h.
- R4: In software-restart mode while running, a B event copies the counter's pre-edge value into the capture register. If the B flag is clear, it sets the B flag. If the B flag is already set, it sets the B error bit instead.
- R5: While run is 0, in either mode, events on both inputs are ignored and the counter is held.
- R6: Hardware-restart mode is select {high,low} = 10. While running, the counter is held until the first B event. Each B event then restarts the counter from the reload value, so the first capture after reset reads 0000h.
- R7: In hardware-restart mode the capture is skipped if the B flag or the B error bit is set. The reload still happens. The flag or error bit is updated as in R4.
- R8: In hardware-restart mode the counter wraps from 0000h to FFFFh.
- R9: An A event sets the A flag, or sets the A error bit if the flag is already set. It never changes the counter or the capture register.
- R10: Writing 1 to a status bit clears it. A clear wins over an event that sets the same bit in the same cycle.
- R11: Each input passes through a two-flop synchronizer and a rising-edge detector. A rising edge acts on the third clock edge after it is applied, and an input held high acts only once.
- R12: Select values 01 and 11 are unsupported. With them the counter is held and events are ignored, even when run is set.
- R13: A reload register write in the same cycle as a hardware restart does not affect that restart, which uses the previous reload value. The new value applies from the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `bus_addr` |
| evt_a_in | input | 1 | Asynchronous event input A |
| evt_b_in | input | 1 | Asynchronous event input B |

## Verification
Two pairs of actions can land on the same edge. A software write-1-to-clear of a status bit can meet a B event that sets that same bit. A write of the reload register can meet a hardware restart that reads it. The bench provokes both by raising input B and placing the bus write exactly on the third edge after the rise, where the synchronized event takes effect. For the first pair, the bench checks that the cleared bit reads 0 while the capture still happened. For the second pair, it checks that the counter restarted from the old reload value and that the next restart uses the new one.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int NEVT   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 3'd0,
        A_CAPT   = 3'd1,
        A_CTRL   = 3'd2,
        A_STAT   = 3'd3,
        A_COUNT  = 3'd4
    } reg_addr_e;

    // Mode select {high, low}
    localparam logic [1:0] MODE_SOFT  = 2'b00;
    localparam logic [1:0] MODE_EVENT = 2'b10;

    // Status bit positions
    localparam int ST_FLAG_A = 0;
    localparam int ST_ERR_A  = 1;
    localparam int ST_FLAG_B = 2;
    localparam int ST_ERR_B  = 3;
endpackage

// File: rtl/crt_edge_sync.sv
// Synchronizes NIN asynchronous event inputs through STAGES flops each and
// emits a one-cycle pulse on each synchronized rising edge.
// Assumes inputs are slower than the clock (each level lasts > STAGES+1 cycles).
module crt_edge_sync #(
    parameter int NIN    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] pins,
    output logic [NIN-1:0] pulse
);
    localparam int SH_W = STAGES + 1;

    for (genvar g = 0; g < NIN; g++) begin : g_ch
        logic [SH_W-1:0] sh;

        // Shift the raw input through the synchronizer plus one history flop
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SH_W-2:0], pins[g]};
        end

        assign pulse[g] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/crt_evt_status.sv
// Flag and overrun-error pair for one event input.
// An event sets the flag when it is clear, otherwise the error bit.
// A clear request wins over a same-cycle event.
module crt_evt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_flag,
    input  logic clr_err,
    output logic flag,
    output logic err
);
    // Update the flag bit
    always_ff @(posedge clk) begin
        if (!rst_n)            flag <= 1'b0;
        else if (clr_flag)     flag <= 1'b0;
        else if (evt && !flag) flag <= 1'b1;
    end

    // Update the overrun error bit
    always_ff @(posedge clk) begin
        if (!rst_n)           err <= 1'b0;
        else if (clr_err)     err <= 1'b0;
        else if (evt && flag) err <= 1'b1;
    end
endmodule

// File: rtl/crt_counter.sv
// Down counter with parallel load and a capture register.
// Load has priority over decrement. When wrap_en is low the count floors at
// zero. Capture samples the pre-edge count.
module crt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         wrap_en,
    input  logic         cap_en,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap
);
    logic at_zero;
    assign at_zero = (cnt == '0);

    // Counter: load, else decrement (floor or wrap at zero)
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (load)                     cnt <= load_val;
        else if (dec && (!at_zero || wrap_en)) cnt <= cnt - 1'b1;
    end

    // Capture register: snapshot of the current count
    always_ff @(posedge clk) begin
        if (!rst_n)      cap <= '0;
        else if (cap_en) cap <= cnt;
    end
endmodule

// File: rtl/cap_reload_timer.sv
// Capture-reload down-counter timer with two event inputs and a register bus.
// Assumes a single synchronous bus: writes act at the clock edge where
// bus_we is high; reads are combinational.
module cap_reload_timer
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              evt_a_in,
    input  logic              evt_b_in
);
    logic             run_q;
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] reload_q;
    logic             counting_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_q;
    logic [NEVT-1:0]  ev_pulse;
    logic [3:0]       stat;

    logic ctrl_wr, reload_wr, stat_wr;
    logic run_set, run_clr;
    logic mode_ok, active;
    logic evt_a, evt_b;
    logic soft_load, hw_load, load;
    logic cap_en, dec;
    logic [3:0] clr;

    assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
    assign reload_wr = bus_we && (bus_addr == A_RELOAD);
    assign stat_wr   = bus_we && (bus_addr == A_STAT);
    assign run_set   = ctrl_wr && bus_wdata[0] && !run_q;
    assign run_clr   = ctrl_wr && !bus_wdata[0];
    assign clr       = stat_wr ? bus_wdata[3:0] : 4'b0;

    assign mode_ok = (mode_q == MODE_SOFT) || (mode_q == MODE_EVENT);
    assign active  = run_q && mode_ok;
    assign evt_a   = active && ev_pulse[0];
    assign evt_b   = active && ev_pulse[1];

    assign soft_load = run_set && (bus_wdata[2:1] == MODE_SOFT);
    assign hw_load   = evt_b && (mode_q == MODE_EVENT);
    assign load      = soft_load || hw_load;
    assign cap_en    = evt_b && ((mode_q == MODE_SOFT) || (!stat[ST_FLAG_B] && !stat[ST_ERR_B]));
    assign dec       = active && counting_q;

    // Control register: run bit and mode select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_SOFT;
        end else if (ctrl_wr) begin
            run_q  <= bus_wdata[0];
            mode_q <= bus_wdata[2:1];
        end
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_wr) reload_q <= bus_wdata;
    end

    // Counting enable: starts on any restart, stops when run is cleared
    always_ff @(posedge clk) begin
        if (!rst_n)       counting_q <= 1'b0;
        else if (run_clr) counting_q <= 1'b0;
        else if (load)    counting_q <= 1'b1;
    end

    crt_edge_sync #(.NIN(NEVT), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({evt_b_in, evt_a_in}),
        .pulse (ev_pulse)
    );

    crt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reload_q),
        .dec      (dec),
        .wrap_en  (mode_q == MODE_EVENT),
        .cap_en   (cap_en),
        .cnt      (cnt),
        .cap      (cap_q)
    );

    logic [NEVT-1:0] st_evt;
    assign st_evt = {evt_b, evt_a};

    for (genvar g = 0; g < NEVT; g++) begin : g_st
        crt_evt_status u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (st_evt[g]),
            .clr_flag (clr[2*g]),
            .clr_err  (clr[2*g+1]),
            .flag     (stat[2*g]),
            .err      (stat[2*g+1])
        );
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        case (bus_addr)
            A_RELOAD: rd_data = reload_q;
            A_CAPT:   rd_data = cap_q;
            A_CTRL:   rd_data = {{(CNT_W-3){1'b0}}, mode_q, run_q};
            A_STAT:   rd_data = {{(CNT_W-4){1'b0}}, stat};
            A_COUNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cap_reload_timer_chk.sv
// Property checker for cap_reload_timer, attached by bind.
module cap_reload_timer_chk
    import crt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              run_q,
    input logic [1:0]        mode_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cap_q,
    input logic [NEVT-1:0]   ev_pulse,
    input logic [3:0]        stat
);
    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

    p_floor_soft_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && mode_q == MODE_SOFT && cnt == '0 && !ctrl_wr |=> cnt == '0);

    p_cap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pulse[1] |=> $stable(cap_q));

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !ctrl_wr |=> $stable(cnt));

    p_hw_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && mode_q == MODE_EVENT && ev_pulse[1] |=> cnt == $past(reload_q));

    p_err_after_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_ERR_B]) |-> $past(stat[ST_FLAG_B]));

    p_err_after_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_ERR_A]) |-> $past(stat[ST_FLAG_A]));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == A_STAT && bus_wdata[ST_FLAG_B] |=> !stat[ST_FLAG_B]);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[1] |=> !ev_pulse[1]);

    p_bad_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_SOFT && mode_q != MODE_EVENT && !ctrl_wr |=> $stable(cnt));
endmodule

bind cap_reload_timer cap_reload_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .reload_q  (reload_q),
    .cnt       (cnt),
    .cap_q     (cap_q),
    .ev_pulse  (ev_pulse),
    .stat      (stat)
);

// File: tb/cap_reload_timer_bench.sv
`timescale 1ns/1ps
module cap_reload_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] rd_data;
    logic        evt_a_in = 1'b0;
    logic        evt_b_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] AR = 3'd0, AC = 3'd1, ACT = 3'd2, AS = 3'd3, AN = 3'd4;

    always #5 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data),
        .evt_a_in(evt_a_in), .evt_b_in(evt_b_in)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = rd_data;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_a_in = 1'b0; evt_b_in = 1'b0;
        edges(3);
        rst_n = 1'b1;
    endtask

    // Raise an input; it acts on the third edge. Optional write on that edge.
    task automatic fire(input bit b, input bit w, input logic [2:0] a, input logic [15:0] d);
        if (b) evt_b_in = 1'b1; else evt_a_in = 1'b1;
        edges(2);
        if (w) begin bus_addr = a; bus_wdata = d; bus_we = 1'b1; end
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic release_in();
        evt_a_in = 1'b0; evt_b_in = 1'b0;
        edges(3);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(AN, v); chk("R1 count", v, 16'h0);
        rd(AC, v); chk("R1 capture", v, 16'h0);
        rd(ACT, v); chk("R1 control", v, 16'h0);
        rd(AS, v); chk("R1 status", v, 16'h0);
    endtask

    task automatic t_regs_badmode();
        logic [15:0] v;
        wr(AR, 16'h1234);
        rd(AR, v); chk("R2 reload readback", v, 16'h1234);
        wr(ACT, 16'h3);
        rd(ACT, v); chk("R2 control readback", v, 16'h3);
        fire(1'b1, 1'b0, AR, 0);
        rd(AN, v); chk("R12 count held", v, 16'h0);
        rd(AS, v); chk("R12 status untouched", v, 16'h0);
        rd(AC, v); chk("R12 capture untouched", v, 16'h0);
        release_in();
        wr(ACT, 16'h0);
    endtask

    task automatic t_soft_run();
        logic [15:0] v;
        wr(AR, 16'd100);
        wr(ACT, 16'h1);
        rd(AN, v); chk("R3 load on run", v, 16'd100);
        edges(5);
        rd(AN, v); chk("R3 count down", v, 16'd95);
        wr(ACT, 16'h0);
        wr(AR, 16'd3);
        wr(ACT, 16'h1);
        edges(10);
        rd(AN, v); chk("R3 stop at zero", v, 16'd0);
    endtask

    task automatic t_soft_capture();
        logic [15:0] c, n;
        wr(ACT, 16'h0);
        wr(AR, 16'd1000);
        wr(ACT, 16'h1);
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, c); rd(AN, n);
        chk("R4 capture value", c, n + 16'd1);
        rd(AS, c); chk("R4 flag set", c, 16'h4);
        release_in();
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, c); rd(AN, n);
        chk("R4 capture with flag set", c, n + 16'd1);
        rd(AS, c); chk("R4 error set", c, 16'hC);
        release_in();
        wr(AS, 16'hF);
        rd(AS, c); chk("R10 clear all", c, 16'h0);
    endtask

    task automatic t_stopped();
        logic [15:0] c0, n0, v;
        wr(ACT, 16'h0);
        rd(AN, n0); rd(AC, c0);
        fire(1'b1, 1'b0, AR, 0);
        release_in();
        fire(1'b0, 1'b0, AR, 0);
        rd(AN, v); chk("R5 count held", v, n0);
        rd(AC, v); chk("R5 capture held", v, c0);
        rd(AS, v); chk("R5 events ignored", v, 16'h0);
        release_in();
        wr(ACT, 16'h4);
        fire(1'b1, 1'b0, AR, 0);
        rd(AS, v); chk("R5 hw mode stopped", v, 16'h0);
        release_in();
        wr(ACT, 16'h0);
    endtask

    task automatic t_hw_mode();
        logic [15:0] v, n0;
        do_reset();
        wr(AR, 16'd50);
        wr(ACT, 16'h5);
        edges(4);
        rd(AN, v); chk("R6 held until first event", v, 16'h0);
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, v); chk("R6 first capture zero", v, 16'h0);
        rd(AN, v); chk("R6 restart value", v, 16'd50);
        rd(AS, v); chk("R6 flag set", v, 16'h4);
        release_in();
        rd(AN, v); chk("R6 counting after restart", v, 16'd47);
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, v); chk("R7 capture blocked by flag", v, 16'h0);
        rd(AN, v); chk("R7 reload with flag", v, 16'd50);
        rd(AS, v); chk("R7 error set", v, 16'hC);
        release_in();
        wr(AS, 16'h4);
        rd(AS, v); chk("R10 clear flag only", v, 16'h8);
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, v); chk("R7 capture blocked by error", v, 16'h0);
        rd(AN, v); chk("R7 reload with error", v, 16'd50);
        release_in();
        wr(AS, 16'hF);
        rd(AN, n0);
        fire(1'b1, 1'b0, AR, 0);
        rd(AC, v); chk("R7 capture after clear", v, n0 - 16'd2);
        release_in();
        fire(1'b1, 1'b1, AR, 16'd77);
        rd(AN, v); chk("R13 restart uses old reload", v, 16'd50);
        rd(AR, v); chk("R13 new reload stored", v, 16'd77);
        release_in();
        fire(1'b1, 1'b0, AR, 0);
        rd(AN, v); chk("R13 next restart uses new", v, 16'd77);
        release_in();
        wr(AR, 16'd2);
        fire(1'b1, 1'b0, AR, 0);
        edges(3);
        rd(AN, v); chk("R8 wrap to FFFF", v, 16'hFFFF);
        release_in();
    endtask

    task automatic t_input_a();
        logic [15:0] c0, v;
        wr(ACT, 16'h0);
        wr(AS, 16'hF);
        wr(AR, 16'd5);
        wr(ACT, 16'h1);
        edges(8);
        rd(AC, c0);
        fire(1'b0, 1'b0, AR, 0);
        rd(AS, v); chk("R9 A flag", v, 16'h1);
        rd(AN, v); chk("R9 count untouched", v, 16'h0);
        release_in();
        fire(1'b0, 1'b0, AR, 0);
        rd(AS, v); chk("R9 A error", v, 16'h3);
        rd(AC, v); chk("R9 capture untouched", v, c0);
        release_in();
        wr(AS, 16'h3);
    endtask

    task automatic t_clear_race();
        logic [15:0] v, n;
        wr(ACT, 16'h0);
        wr(AS, 16'hF);
        wr(AR, 16'd1000);
        wr(ACT, 16'h1);
        fire(1'b1, 1'b1, AS, 16'h4);
        rd(AS, v); chk("R10 clear beats flag set", v, 16'h0);
        rd(AC, v); rd(AN, n); chk("R10 capture still done", v, n + 16'd1);
        release_in();
        fire(1'b1, 1'b0, AR, 0);
        release_in();
        fire(1'b1, 1'b1, AS, 16'h8);
        rd(AS, v); chk("R10 clear beats error set", v, 16'h4);
        release_in();
        wr(AS, 16'hF);
    endtask

    task automatic t_sync();
        logic [15:0] v;
        evt_b_in = 1'b1;
        edges(1); rd(AS, v); chk("R11 no action edge 1", v, 16'h0);
        edges(1); rd(AS, v); chk("R11 no action edge 2", v, 16'h0);
        edges(1); rd(AS, v); chk("R11 acts on edge 3", v, 16'h4);
        wr(AS, 16'hF);
        edges(6);
        rd(AS, v); chk("R11 held high acts once", v, 16'h0);
        release_in();
    endtask

    initial begin
        t_reset();
        t_regs_badmode();
        t_soft_run();
        t_soft_capture();
        t_stopped();
        t_hw_mode();
        t_input_a();
        t_clear_race();
        t_sync();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule